// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block is the serial sample port of a voice codec. An external bit clock and a frame sync mark out a frame. Inside that frame the port shifts one transmit word out on the serial output and captures one receive word from the serial input. Both directions use the same selected time slot. All logic runs on one fast system clock. The bit clock, the frame sync and the serial input pass through a synchronizer, and edge events are taken from the synchronized copies. The serial output has a separate enable so that the pad can be tri-stated.

In companded operation a slot carries one byte. The byte sits in the first channel slot or in the second. The second slot follows the first directly, or after a gap of two bit periods. A seven-bit option leaves the least significant bit period undriven and discards the received bit in that position. In linear operation the slot is sixteen bits long and always starts at the first bit position. It carries a 14-bit sample followed by two zero bits. Three timing modes are available: delayed, non-delayed with MSB first, and non-delayed with LSB first. A loopback mode returns the last received word in the next frame's transmit slot and mutes both parallel streams.

The transmit side is a valid/ready stream with a one-word holding register. A word is accepted when `tx_valid` and `tx_ready` are both high at a clock edge. The frame start consumes the held word. If no word is held at frame start, the slot carries zeros, because the serial line cannot wait. The receive side is a valid/ready stream with a one-word output register. `rx_valid` stays high until `rx_ready` is seen. A newly completed word replaces an unread one, because the serial input cannot be held back.

Top module: `pcm_slot_port`

## Requirements
- R1: With `tmode[1]`=0 (delayed timing) the first slot bit is driven on the bit-clock rising edge after the one that first samples `fsync` high. With `tmode[1]`=1 the first bit is driven on that same rising edge.
- R2: With `tmode`=2'b11 the word goes out and comes in least significant bit first. In every other mode the order is most significant bit first.
- R3: In companded mode, `chan_b2`=0 selects the slot at bit positions 0..7 and `chan_b2`=1 selects the slot at 8..15 (`fmt_gap`=0) or 10..17 (`fmt_gap`=1). Positions count from the first bit of R1. The same slot is used in both directions.
- R4: `dx` changes only on bit-clock rising edges. `dx_oe` is 0 at every bit position outside the selected slot.
- R5: `dr` is sampled on bit-clock falling edges. After the last bit of the slot, the word appears on `rx_data` with `rx_valid`=1. A companded byte appears in `rx_data[7:0]` with the upper bits zero.
- R6: With `b7_mode`=1 in companded mode, `dx_oe` is 0 during the bit period of byte bit 0, and received byte bit 0 is stored as 0.
- R7: With `linear`=1 the slot covers positions 0..15. Transmit word bits 15..2 carry `tx_data[13:0]` and bits 1..0 are 0. `rx_data` receives bits 15..2 of the captured word. `chan_b2`, `fmt_gap` and `b7_mode` have no effect in linear mode.
- R8: `tx_ready` is 1 while the holding register is empty and loopback is off. A held word is consumed at frame start. With no held word, a frame transmits zeros.
- R9: `rx_valid` stays 1 until a clock edge with `rx_ready`=1. A new word replaces an unread one.
- R10: With `loopback`=1, a frame transmits in its slot the word captured in the previous frame, `tx_ready` is 0, and `rx_valid` is not raised.
- R11: Mode inputs are taken once, at frame start. Changes later in the frame take effect at the next frame.
- R12: After reset, `dx_oe`=0, `rx_valid`=0 and `tx_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame sync |
| dr | input | 1 | Serial receive data |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Output enable for the `dx` pad |
| tmode | input | 2 | Timing mode: 0x delayed, 10 non-delayed MSB first, 11 non-delayed LSB first |
| fmt_gap | input | 1 | Two-bit gap before the second channel slot |
| b7_mode | input | 1 | Seven-bit mode (companded only) |
| linear | input | 1 | 1 = 14-bit linear in a 16-bit slot, 0 = 8-bit companded |
| chan_b2 | input | 1 | 1 = second channel slot, 0 = first channel slot |
| loopback | input | 1 | Digital loopback |
| tx_data | input | 14 | Transmit word (companded uses [7:0]) |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Holding register can accept a word |
| rx_data | output | 14 | Received word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |

## Verification
The in-line assertions watch stream and timing invariants on every cycle. The output enable may only rise after a bit-clock rising edge. An unread receive word must stay valid. An accepted transmit word must close the holding register. No receive word may be raised while loopback is active. Only the bench scenarios can show which bit appears at which position. This covers the delayed and non-delayed offsets, bit reversal, slot placement with and without the gap, the floated LSB, the linear slot layout, mode capture at frame start and the one-frame loopback delay. The bench compares every bit period of each frame against an independent slot model.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned LIN_W    = 14;
  localparam int unsigned LIN_SLOT = 16;
  localparam int unsigned GAP_W    = 2;
  localparam int unsigned WORD_W   = LIN_SLOT;
  localparam int unsigned WBIT_W   = $clog2(WORD_W);

  // Frame configuration captured at frame start
  typedef struct packed {
    logic linear;
    logic gap;
    logic b7;
    logic chan_b2;
    logic loopback;
    logic delayed;
    logic reversed;
  } pcm_mode_t;

  // Where a bit position falls inside the selected slot
  typedef struct packed {
    logic              hit;
    logic [WBIT_W-1:0] wbit;
    logic              last;
    logic              float_lsb;
  } slot_dec_t;

  function automatic slot_dec_t decode_slot(input int unsigned cnt, input pcm_mode_t m);
    slot_dec_t   d;
    int unsigned off;
    int unsigned start;
    int unsigned len;
    int unsigned j;
    d     = '0;
    off   = m.delayed ? 1 : 0;
    len   = m.linear ? LIN_SLOT : BYTE_W;
    start = (m.linear || !m.chan_b2) ? 0 : (BYTE_W + (m.gap ? GAP_W : 0));
    if (cnt >= off + start && cnt < off + start + len) begin
      j           = cnt - off - start;
      d.hit       = 1'b1;
      d.wbit      = WBIT_W'(m.reversed ? j : len - 1 - j);
      d.last      = (j == len - 1);
      d.float_lsb = !m.linear && m.b7 && (d.wbit == '0);
    end
    return d;
  endfunction

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fsync,
  input  logic dr,
  output logic rise_evt,
  output logic fall_evt,
  output logic fs_s,
  output logic dr_s
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [2:0] chain [SYNC_STAGES];
  logic       bclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
      bclk_prev <= 1'b0;
    end else begin
      chain[0] <= {bclk, fsync, dr};
      for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
      bclk_prev <= chain[LAST][2];
    end
  end

  assign rise_evt = chain[LAST][2] && !bclk_prev;
  assign fall_evt = !chain[LAST][2] && bclk_prev;
  assign fs_s     = chain[LAST][1];
  assign dr_s     = chain[LAST][0];

endmodule

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
  import pcm_port_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_evt,
  input  logic              fs_s,
  input  pcm_mode_t         mode_in,
  output logic              frame_start,
  output logic              nxt_linear,
  output logic              nxt_loopback,
  output logic              q_linear,
  output logic              q_loopback,
  output logic              tx_hit,
  output logic [WBIT_W-1:0] tx_wbit,
  output logic              tx_float,
  output slot_dec_t         dec_fall
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             fs_last;
  pcm_mode_t        mode_q, mode_nxt;
  slot_dec_t        dec_rise;

  always_comb begin
    frame_start = rise_evt && fs_s && !fs_last;
    if (frame_start)           cnt_nxt = '0;
    else if (cnt_q == CNT_MAX) cnt_nxt = cnt_q;
    else                       cnt_nxt = cnt_q + 1'b1;
    mode_nxt = frame_start ? mode_in : mode_q;
    dec_rise = decode_slot(32'(cnt_nxt), mode_nxt);
    dec_fall = decode_slot(32'(cnt_q), mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_MAX;
      fs_last <= 1'b0;
      mode_q  <= '0;
    end else if (rise_evt) begin
      cnt_q   <= cnt_nxt;
      fs_last <= fs_s;
      mode_q  <= mode_nxt;
    end
  end

  assign nxt_linear   = mode_nxt.linear;
  assign nxt_loopback = mode_nxt.loopback;
  assign q_linear     = mode_q.linear;
  assign q_loopback   = mode_q.loopback;
  assign tx_hit       = dec_rise.hit;
  assign tx_wbit      = dec_rise.wbit;
  assign tx_float     = dec_rise.float_lsb;

endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
  import pcm_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_evt,
  input  logic              frame_start,
  input  logic              nxt_linear,
  input  logic              nxt_loopback,
  input  logic              q_loopback,
  input  logic              tx_hit,
  input  logic [WBIT_W-1:0] tx_wbit,
  input  logic              tx_float,
  input  logic [WORD_W-1:0] lb_word,
  input  logic [LIN_W-1:0]  tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              dx,
  output logic              dx_oe
);
  logic [LIN_W-1:0]  hold_q;
  logic              full_q;
  logic [WORD_W-1:0] word_q, word_nxt, src;
  logic              accept, drive;

  assign tx_ready = !full_q && !q_loopback;
  assign accept   = tx_valid && tx_ready;

  always_comb begin
    if (nxt_loopback)    src = lb_word;
    else if (!full_q)    src = '0;
    else if (nxt_linear) src = {hold_q, 2'b00};
    else                 src = {{(WORD_W-BYTE_W){1'b0}}, hold_q[BYTE_W-1:0]};
    word_nxt = frame_start ? src : word_q;
    drive    = tx_hit && !tx_float;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (accept) begin
      hold_q <= tx_data;
      full_q <= 1'b1;
    end else if (frame_start && !nxt_loopback) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      dx     <= 1'b0;
      dx_oe  <= 1'b0;
    end else if (rise_evt) begin
      word_q <= word_nxt;
      dx_oe  <= drive;
      dx     <= drive ? word_nxt[tx_wbit] : 1'b0;
    end
  end

  // R4
  oe_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dx_oe) |-> $past(rise_evt));

  // R8
  tx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
  import pcm_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_evt,
  input  logic              dr_s,
  input  slot_dec_t         dec_fall,
  input  logic              q_linear,
  input  logic              q_loopback,
  input  logic              rx_ready,
  output logic [LIN_W-1:0]  rx_data,
  output logic              rx_valid,
  output logic [WORD_W-1:0] lb_word
);
  logic [WORD_W-1:0] sh_q, word_now;
  logic [LIN_W-1:0]  fmt;
  logic              bit_in, done;

  always_comb begin
    bit_in   = dec_fall.float_lsb ? 1'b0 : dr_s;
    word_now = sh_q;
    word_now[dec_fall.wbit] = bit_in;
    fmt  = q_linear ? word_now[WORD_W-1:WORD_W-LIN_W]
                    : {{(LIN_W-BYTE_W){1'b0}}, word_now[BYTE_W-1:0]};
    done = fall_evt && dec_fall.hit && dec_fall.last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      lb_word <= '0;
    end else if (fall_evt && dec_fall.hit) begin
      sh_q <= word_now;
      if (dec_fall.last) lb_word <= word_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else if (done && !q_loopback) begin
      rx_data  <= fmt;
      rx_valid <= 1'b1;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  // R10
  lb_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_loopback |=> !$rose(rx_valid));

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             fsync,
  input  logic             dr,
  output logic             dx,
  output logic             dx_oe,
  input  logic [1:0]       tmode,
  input  logic             fmt_gap,
  input  logic             b7_mode,
  input  logic             linear,
  input  logic             chan_b2,
  input  logic             loopback,
  input  logic [LIN_W-1:0] tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [LIN_W-1:0] rx_data,
  output logic             rx_valid,
  input  logic             rx_ready
);
  logic              rise_evt, fall_evt, fs_s, dr_s, frame_start;
  logic              nxt_linear, nxt_loopback, q_linear, q_loopback;
  logic              tx_hit, tx_float;
  logic [WBIT_W-1:0] tx_wbit;
  logic [WORD_W-1:0] lb_word;
  slot_dec_t         dec_fall;
  pcm_mode_t         mode_in;

  always_comb begin
    mode_in.linear   = linear;
    mode_in.gap      = fmt_gap;
    mode_in.b7       = b7_mode;
    mode_in.chan_b2  = chan_b2;
    mode_in.loopback = loopback;
    mode_in.delayed  = !tmode[1];
    mode_in.reversed = tmode[1] && tmode[0];
  end

  pcm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .dr(dr),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .fs_s(fs_s), .dr_s(dr_s)
  );

  pcm_slot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .fs_s(fs_s), .mode_in(mode_in),
    .frame_start(frame_start), .nxt_linear(nxt_linear), .nxt_loopback(nxt_loopback),
    .q_linear(q_linear), .q_loopback(q_loopback), .tx_hit(tx_hit), .tx_wbit(tx_wbit),
    .tx_float(tx_float), .dec_fall(dec_fall)
  );

  pcm_tx_path u_tx (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .frame_start(frame_start),
    .nxt_linear(nxt_linear), .nxt_loopback(nxt_loopback), .q_loopback(q_loopback),
    .tx_hit(tx_hit), .tx_wbit(tx_wbit), .tx_float(tx_float), .lb_word(lb_word),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .dx(dx), .dx_oe(dx_oe)
  );

  pcm_rx_path u_rx (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .dr_s(dr_s), .dec_fall(dec_fall),
    .q_linear(q_linear), .q_loopback(q_loopback), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .lb_word(lb_word)
  );

endmodule

// File: tb/pcm_slot_port_tb.sv
module pcm_slot_port_tb;
  localparam int HALF   = 8;
  localparam int FRAME  = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0, dr = 1'b0;
  logic dx, dx_oe;
  logic [1:0] tmode = 2'b00;
  logic fmt_gap = 1'b0, b7_mode = 1'b0, linear = 1'b0, chan_b2 = 1'b0, loopback = 1'b0;
  logic [13:0] tx_data = '0;
  logic tx_valid = 1'b0, tx_ready;
  logic [13:0] rx_data;
  logic rx_valid, rx_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // saved frame configuration
  bit m_dly, m_rev, m_lin, m_b2, m_gap, m_b7;
  logic [7:0] last_byte;

  always #10 clk = ~clk;

  pcm_slot_port u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .dr(dr), .dx(dx), .dx_oe(dx_oe),
    .tmode(tmode), .fmt_gap(fmt_gap), .b7_mode(b7_mode), .linear(linear),
    .chan_b2(chan_b2), .loopback(loopback), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void slot_model(input int c, output bit hit, output int wb);
    int start, len, k;
    start = (m_lin || !m_b2) ? 0 : (m_gap ? 10 : 8);
    len   = m_lin ? 16 : 8;
    k     = c - (m_dly ? 1 : 0) - start;
    hit   = (k >= 0) && (k < len);
    wb    = m_rev ? k : len - 1 - k;
  endfunction

  function automatic logic [15:0] tx_word(input logic [13:0] d, input bit lin);
    return lin ? {d, 2'b00} : {8'h00, d[7:0]};
  endfunction

  function automatic logic [13:0] rx_exp(input logic [15:0] w);
    if (m_lin) return w[15:2];
    return {6'h00, w[7:1], m_b7 ? 1'b0 : w[0]};
  endfunction

  task automatic push(input logic [13:0] d);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic run_frame(input string req, input logic [15:0] txw,
                           input logic [15:0] rxw, input bit flip);
    bit hit;
    int wb;
    bit exp_oe;
    m_dly = !tmode[1];
    m_rev = (tmode == 2'b11);
    m_lin = linear; m_b2 = chan_b2; m_gap = fmt_gap; m_b7 = b7_mode;
    for (int c = 0; c < FRAME; c++) begin
      @(negedge clk);
      slot_model(c, hit, wb);
      bclk  = 1'b1;
      fsync = (c == 0);
      dr    = hit ? rxw[wb] : 1'($urandom);
      if (flip && c == 2) begin chan_b2 = !chan_b2; fmt_gap = !fmt_gap; end
      repeat (6) @(negedge clk);
      exp_oe = hit && !(m_b7 && !m_lin && wb == 0);
      chk({req, " dx_oe"}, dx_oe, exp_oe);
      if (exp_oe) chk({req, " dx"}, dx, txw[wb]);
      repeat (2) @(negedge clk);
      bclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    if (!m_lin) last_byte = rx_exp(rxw)[7:0];
  endtask

  initial begin
    logic [13:0] d;
    logic [15:0] r;
    bit pushed;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    // R12 reset state
    chk("R12 dx_oe", dx_oe, 0);
    chk("R12 rx_valid", rx_valid, 0);
    chk("R12 tx_ready", tx_ready, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R4: delayed, MSB first, first channel
    push(14'h00A5);
    chk("R8 tx_ready after accept", tx_ready, 0);
    run_frame("R1/R2/R4 delayed", tx_word(14'h00A5, 0), 16'h003C, 0);
    chk("R5 rx_valid", rx_valid, 1);
    chk("R5 rx_data", rx_data, 14'h003C);
    chk("R8 tx_ready after frame", tx_ready, 1);

    // R8 underrun sends zeros; R9 overwrite
    run_frame("R8 underrun", 16'h0000, 16'h00C3, 0);
    chk("R9 overwrite valid", rx_valid, 1);
    chk("R9 overwrite data", rx_data, 14'h00C3);
    ack();
    chk("R9 cleared by ready", rx_valid, 0);

    // R1 R3: non-delayed, second channel, no gap
    tmode = 2'b10; chan_b2 = 1'b1; fmt_gap = 1'b0;
    push(14'h005A);
    run_frame("R1/R3 nondelayed b2", tx_word(14'h005A, 0), 16'h0081, 0);
    chk("R3 rx_data b2", rx_data, 14'h0081);
    ack();

    // R2 R3: reversed, second channel with gap
    tmode = 2'b11; fmt_gap = 1'b1;
    push(14'h0037);
    run_frame("R2/R3 reversed gap", tx_word(14'h0037, 0), 16'h00E4, 0);
    chk("R2 rx_data reversed", rx_data, 14'h00E4);
    ack();

    // R6: seven-bit mode
    tmode = 2'b10; chan_b2 = 1'b0; fmt_gap = 1'b0; b7_mode = 1'b1;
    push(14'h00FF);
    run_frame("R6 b7", tx_word(14'h00FF, 0), 16'h0055, 0);
    chk("R6 rx lsb dropped", rx_data, 14'h0054);
    ack();

    // R7: linear delayed
    b7_mode = 1'b0; linear = 1'b1; tmode = 2'b00;
    push(14'h2ABC);
    run_frame("R7 linear", tx_word(14'h2ABC, 1), 16'hBEEF, 0);
    chk("R7 rx linear", rx_data, 14'h2FBB);
    ack();

    // R7: linear reversed, companded-only options ignored
    tmode = 2'b11; chan_b2 = 1'b1; fmt_gap = 1'b1; b7_mode = 1'b1;
    push(14'h1234);
    run_frame("R7 linear ignores b2/gap/b7", tx_word(14'h1234, 1), 16'h8001, 0);
    chk("R7 rx linear reversed", rx_data, 14'h2000);
    ack();

    // R11: mode change mid-frame has no effect
    linear = 1'b0; b7_mode = 1'b0; tmode = 2'b10; chan_b2 = 1'b0; fmt_gap = 1'b0;
    push(14'h0096);
    run_frame("R11 midframe change", tx_word(14'h0096, 0), 16'h006B, 1);
    chk("R11 rx_data", rx_data, 14'h006B);
    ack();
    chan_b2 = 1'b0; fmt_gap = 1'b0;

    // R10: loopback, two frames
    loopback = 1'b1;
    run_frame("R10 loopback 1", {8'h00, last_byte}, 16'h00D2, 0);
    chk("R10 tx_ready low", tx_ready, 0);
    chk("R10 rx muted", rx_valid, 0);
    run_frame("R10 loopback 2", 16'h00D2, 16'h0019, 0);
    chk("R10 rx muted 2", rx_valid, 0);
    loopback = 1'b0;
    run_frame("R8 after loopback", 16'h0000, 16'h0044, 0);
    chk("R8 tx_ready restored", tx_ready, 1);
    ack();

    // random frames
    for (int n = 0; n < 30; n++) begin
      tmode   = 2'($urandom);
      fmt_gap = 1'($urandom);
      b7_mode = 1'($urandom);
      linear  = 1'($urandom);
      chan_b2 = 1'($urandom);
      d       = 14'($urandom);
      r       = 16'($urandom);
      pushed  = ($urandom % 4) != 0;
      if (pushed) push(d);
      run_frame("R1/R2/R3/R6/R7 random", pushed ? tx_word(d, linear) : 16'h0000, r, 0);
      chk("R5 random rx_valid", rx_valid, 1);
      chk("R5 random rx_data", rx_data, rx_exp(r));
      ack();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule